// File: doc/BRIEF.md
# One-Wire Search Triplet Engine

This block carries out a single step of a one-wire ROM search. After one start pulse it reads an identity bit and then the complement of that bit through a bit-slot master. From the two sampled values it works out which branch of the search tree to follow. It then writes that direction back on the bus, except when no device answered. It latches the direction preferred by the search controller when the step starts, and uses that direction only when devices sit on both branches.

The controller gets a three-bit outcome code and a one-cycle completion pulse. A slot that never reports completion ends the step after a set number of waiting cycles. In that case the engine returns the "no device" code, raises an error flag and issues no further slots. The full 64-bit search loop, discrepancy bookkeeping and CRC checking belong to the controller that drives this engine.

Top module: `ow_triplet_engine`

## Requirements
- R1: After an accepted start, the engine requests slots in a fixed order: read slot (identity bit), then read slot (complement bit), then write slot. Each request is a one-cycle pulse on `slot_rd_o` or `slot_wr_o`. The two are never high together. A new request comes only after the previous slot has reported done.
- R2: When both sampled bits are 1, no write slot is requested and the result is 3'b011.
- R3: When both sampled bits are 0, the latched preferred direction is written. The result is 3'b100 for direction 1 and 3'b000 for direction 0.
- R4: When exactly one sampled bit is 0, the identity bit is written as the direction. The result is 3'b101 when the identity bit is 1 and 3'b010 when it is 0.
- R5: Result bit 0 holds the identity bit, bit 1 holds the complement bit and bit 2 holds the direction taken. `slot_wbit_o` carries that direction while the write slot is requested.
- R6: `slot_done_i` counts only while the engine waits on a slot it has requested. A done seen in the request cycle or while idle has no effect.
- R7: When a slot stays without done for TIMEOUT_CYC waiting cycles, the step aborts. It gives result 3'b011 with `err_o` = 1 and requests no further slot.
- R8: When done arrives in the same cycle the waiting limit is reached, the done is accepted and the step continues normally.
- R9: A start while busy is ignored. The preferred direction is sampled only in the cycle the start is accepted.
- R10: `done_o` is a one-cycle pulse. `result_o` and `err_o` change only in that cycle and hold until the next completion.
- R11: After reset the engine is idle. No request is active, `done_o`, `err_o` and `busy_o` are 0 and `result_o` is 3'b000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts one search step when idle |
| dir_i | input | 1 | Preferred branch direction, sampled at start |
| slot_rd_o | output | 1 | One-cycle read-slot request |
| slot_wr_o | output | 1 | One-cycle write-slot request |
| slot_wbit_o | output | 1 | Bit value for the write slot |
| slot_done_i | input | 1 | Slot completion from the bit master |
| slot_bit_i | input | 1 | Sampled bus value, valid with slot_done_i on read slots |
| busy_o | output | 1 | Step in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 3 | {direction, complement bit, identity bit} |
| err_o | output | 1 | Step ended by slot timeout |

## Verification
Two events can land in the same cycle: a slot's done and the expiry of the waiting limit. The bench provokes this by holding back the slot response for exactly TIMEOUT_CYC waiting cycles. It expects a normal three-slot step with no error flag. It then holds the response back one cycle longer and expects an abort with code 3'b011, the error flag set and no later request. A second collision, a start pulse that arrives during a busy step, is judged by the single completion pulse and by the result, which must follow the first direction latched.

// File: rtl/ow_trip_pkg.sv
package ow_trip_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ID_REQ  = 3'd1,
    ST_ID_WAIT = 3'd2,
    ST_CP_REQ  = 3'd3,
    ST_CP_WAIT = 3'd4,
    ST_WR_REQ  = 3'd5,
    ST_WR_WAIT = 3'd6
  } trip_state_e;

  // Outcome field order: {direction, complement, identity}
  typedef struct packed {
    logic dir;
    logic cp;
    logic id;
  } trip_res_t;

  localparam logic [2:0] RES_NO_DEVICE = 3'b011;

endpackage

// File: rtl/ow_branch_pick.sv
module ow_branch_pick (
  input  logic id_bit,
  input  logic cp_bit,
  input  logic pref_dir,
  output logic no_dev,
  output logic take_dir
);

  always_comb begin
    no_dev   = id_bit & cp_bit;
    take_dir = (id_bit | cp_bit) ? id_bit : pref_dir;
  end

endmodule

// File: rtl/ow_slot_timer.sv
module ow_slot_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);

  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en  = clr | run;
    cnt_d   = clr ? '0 : cnt_q + 1'b1;
    expired = (cnt_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/ow_triplet_engine.sv
module ow_triplet_engine
  import ow_trip_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       dir_i,
  output logic       slot_rd_o,
  output logic       slot_wr_o,
  output logic       slot_wbit_o,
  input  logic       slot_done_i,
  input  logic       slot_bit_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [2:0] result_o,
  output logic       err_o
);

  trip_state_e state_q, state_d;
  logic        dir_q, dir_d;
  logic        id_q, id_d;
  logic        cp_q, cp_d;
  logic        wbit_q, wbit_d;
  trip_res_t   res_q, res_d;
  logic        err_q, err_d;
  logic        done_q, done_d;
  logic        res_en;

  logic in_req, in_wait, expired;
  logic no_dev, take_dir;

  always_comb begin
    in_req  = (state_q == ST_ID_REQ) || (state_q == ST_CP_REQ) || (state_q == ST_WR_REQ);
    in_wait = (state_q == ST_ID_WAIT) || (state_q == ST_CP_WAIT) || (state_q == ST_WR_WAIT);
  end

  ow_slot_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (in_req),
    .run     (in_wait & ~slot_done_i),
    .expired (expired)
  );

  // Complement bit comes straight from the slot sample in the decision cycle
  ow_branch_pick u_pick (
    .id_bit   (id_q),
    .cp_bit   (slot_bit_i),
    .pref_dir (dir_q),
    .no_dev   (no_dev),
    .take_dir (take_dir)
  );

  always_comb begin
    state_d = state_q;
    dir_d   = dir_q;
    id_d    = id_q;
    cp_d    = cp_q;
    wbit_d  = wbit_q;
    res_d   = res_q;
    err_d   = err_q;
    done_d  = 1'b0;
    res_en  = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          dir_d   = dir_i;
          state_d = ST_ID_REQ;
        end
      end
      ST_ID_REQ: state_d = ST_ID_WAIT;
      ST_CP_REQ: state_d = ST_CP_WAIT;
      ST_WR_REQ: state_d = ST_WR_WAIT;
      ST_ID_WAIT: begin
        if (slot_done_i) begin
          id_d    = slot_bit_i;
          state_d = ST_CP_REQ;
        end else if (expired) begin
          res_en  = 1'b1;
        end
      end
      ST_CP_WAIT: begin
        if (slot_done_i) begin
          cp_d = slot_bit_i;
          if (no_dev) begin
            res_en = 1'b1;
          end else begin
            wbit_d  = take_dir;
            state_d = ST_WR_REQ;
          end
        end else if (expired) begin
          res_en = 1'b1;
        end
      end
      ST_WR_WAIT: begin
        if (slot_done_i || expired) begin
          res_en = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    // Completion: normal write end, no-device end, or abort
    if (res_en) begin
      done_d  = 1'b1;
      state_d = ST_IDLE;
      if (!slot_done_i) begin
        res_d = RES_NO_DEVICE;
        err_d = 1'b1;
      end else if (state_q == ST_WR_WAIT) begin
        res_d = '{dir: wbit_q, cp: cp_q, id: id_q};
        err_d = 1'b0;
      end else begin
        res_d = RES_NO_DEVICE;
        err_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dir_q   <= 1'b0;
      id_q    <= 1'b0;
      cp_q    <= 1'b0;
      wbit_q  <= 1'b0;
      res_q   <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      dir_q   <= dir_d;
      id_q    <= id_d;
      cp_q    <= cp_d;
      wbit_q  <= wbit_d;
      done_q  <= done_d;
      if (res_en) begin
        res_q <= res_d;
        err_q <= err_d;
      end
    end
  end

  always_comb begin
    slot_rd_o   = (state_q == ST_ID_REQ) || (state_q == ST_CP_REQ);
    slot_wr_o   = (state_q == ST_WR_REQ);
    slot_wbit_o = wbit_q;
    busy_o      = (state_q != ST_IDLE);
    done_o      = done_q;
    result_o    = res_q;
    err_o       = err_q;
  end

endmodule

// File: rtl/ow_triplet_engine_chk.sv
module ow_triplet_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       slot_rd_o,
  input logic       slot_wr_o,
  input logic       busy_o,
  input logic       done_o,
  input logic [2:0] result_o,
  input logic       err_o
);

  // R1: requests never overlap and are single-cycle
  assert_req_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({slot_rd_o, slot_wr_o}));
  assert_rd_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_rd_o |=> !slot_rd_o);
  assert_wr_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_wr_o |=> !slot_wr_o);

  // R4/R5: identity 1 with complement 0 always reports direction 1
  assert_forced_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && result_o[1:0] == 2'b01) |-> result_o[2]);

  // R7: an aborted step reports the no-device code
  assert_abort_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o) |-> (result_o == 3'b011));

  // R10: single-cycle done, outputs held between completions
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(result_o) && $stable(err_o)));
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

endmodule

bind ow_triplet_engine ow_triplet_engine_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .slot_rd_o (slot_rd_o),
  .slot_wr_o (slot_wr_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .result_o  (result_o),
  .err_o     (err_o)
);

// File: tb/ow_triplet_engine_test.sv
`timescale 1ns/1ps
module ow_triplet_engine_test;

  localparam int TMO = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, dir_i, slot_done_i, slot_bit_i;
  logic       slot_rd_o, slot_wr_o, slot_wbit_o, busy_o, done_o, err_o;
  logic [2:0] result_o;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  ow_triplet_engine #(.TIMEOUT_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_i(dir_i),
    .slot_rd_o(slot_rd_o), .slot_wr_o(slot_wr_o), .slot_wbit_o(slot_wbit_o),
    .slot_done_i(slot_done_i), .slot_bit_i(slot_bit_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .err_o(err_o)
  );

  // {id, cp, dir, expected result}
  localparam logic [5:0] VEC [8] = '{
    {3'b000, 3'b000}, {3'b001, 3'b100}, {3'b010, 3'b010}, {3'b011, 3'b010},
    {3'b100, 3'b101}, {3'b101, 3'b101}, {3'b110, 3'b011}, {3'b111, 3'b011}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One step; slave answers each request after lat negedges (lat > TMO+... means abort)
  task automatic run_op(input logic id, input logic cp, input logic dir,
                        input int lat, input bit restart,
                        output logic [2:0] res, output logic er,
                        output int nrd, output int nwr, output logic wb,
                        output int ndone, output int extra_req);
    int  cyc = 0;
    bit  fin = 0;
    logic bitv;
    nrd = 0; nwr = 0; wb = 1'bx; ndone = 0; extra_req = 0; res = 'x; er = 1'bx;
    @(negedge clk); start_i = 1'b1; dir_i = dir;
    while (!fin && cyc < 400) begin
      @(negedge clk); cyc++;
      start_i = 1'b0; dir_i = ~dir; slot_done_i = 1'b0;
      if (done_o) begin
        res = result_o; er = err_o; ndone++; fin = 1;
      end else if (slot_rd_o || slot_wr_o) begin
        if (slot_rd_o) begin
          nrd++; bitv = (nrd == 1) ? id : cp;
          if (restart && nrd == 1) start_i = 1'b1;
        end else begin
          nwr++; wb = slot_wbit_o; bitv = 1'b0;
        end
        for (int k = 1; k <= lat; k++) begin
          @(negedge clk); cyc++; start_i = 1'b0;
          if (done_o) begin
            res = result_o; er = err_o; ndone++; fin = 1; break;
          end
        end
        if (!fin) begin slot_done_i = 1'b1; slot_bit_i = bitv; end
      end
    end
    if (!fin) begin
      bad++; total++;
      $display("FAIL R1 step never completed actual=0 expected=1");
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (done_o) ndone++;
      if (slot_rd_o || slot_wr_o) extra_req++;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 150000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [2:0] res; logic er, wb; int nrd, nwr, nd, xr;
    rst_n = 1'b0; start_i = 1'b0; dir_i = 1'b0; slot_done_i = 1'b0; slot_bit_i = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 rd", slot_rd_o, 0);
    check("R11 wr", slot_wr_o, 0);
    check("R11 busy", busy_o, 0);
    check("R11 done", done_o, 0);
    check("R11 result", result_o, 0);
    check("R11 err", err_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Table walk: R2 R3 R4 R5 R1
    for (int i = 0; i < 8; i++) begin
      logic [2:0] exp_res;
      exp_res = VEC[i][2:0];
      run_op(VEC[i][5], VEC[i][4], VEC[i][3], 1 + (i % 3), 1'b0, res, er, nrd, nwr, wb, nd, xr);
      check("R5 result", res, exp_res);
      check("R7 err clear", er, 0);
      check("R1 read slots", nrd, 2);
      check((exp_res == 3'b011) ? "R2 no write" : "R1 one write", nwr, (exp_res == 3'b011) ? 0 : 1);
      if (exp_res != 3'b011) check(VEC[i][5] ^ VEC[i][4] ? "R4 wbit" : "R3 wbit", wb, exp_res[2]);
      check("R10 single done", nd, 1);
      check("R10 result held", result_o, exp_res);
    end

    // R6: done while idle has no effect
    @(negedge clk); slot_done_i = 1'b1; slot_bit_i = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R6 idle done ignored", {slot_rd_o, slot_wr_o, done_o, busy_o}, 0);
    end
    slot_done_i = 1'b0;

    // R6: done in the request cycle is ignored; the engine keeps waiting
    @(negedge clk); start_i = 1'b1; dir_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check("R6 rd request", slot_rd_o, 1);
    slot_done_i = 1'b1; slot_bit_i = 1'b0;
    @(negedge clk); slot_done_i = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check("R6 still waiting", {slot_rd_o, slot_wr_o, done_o}, 0);
    end
    slot_done_i = 1'b1; slot_bit_i = 1'b0;
    @(negedge clk); slot_done_i = 1'b0;
    check("R6 complement request after real done", slot_rd_o, 1);
    @(negedge clk); slot_done_i = 1'b1; slot_bit_i = 1'b1;
    @(negedge clk); slot_done_i = 1'b0;
    check("R4 write request", slot_wr_o, 1);
    check("R4 wbit", slot_wbit_o, 0);
    @(negedge clk); slot_done_i = 1'b1;
    @(negedge clk); slot_done_i = 1'b0;
    check("R4 done", done_o, 1);
    check("R4 result", result_o, 3'b010);

    // R9: start while busy ignored, direction latched at start
    run_op(1'b0, 1'b0, 1'b1, 2, 1'b1, res, er, nrd, nwr, wb, nd, xr);
    check("R9 latched dir result", res, 3'b100);
    check("R9 single done", nd, 1);
    check("R9 no extra slot", xr, 0);

    // R8: done coincides with limit -> accepted
    run_op(1'b1, 1'b0, 1'b0, TMO, 1'b0, res, er, nrd, nwr, wb, nd, xr);
    check("R8 result", res, 3'b101);
    check("R8 err", er, 0);
    check("R8 write done", nwr, 1);

    // R7: one cycle late -> abort
    run_op(1'b0, 1'b0, 1'b0, TMO + 1, 1'b0, res, er, nrd, nwr, wb, nd, xr);
    check("R7 result", res, 3'b011);
    check("R7 err", er, 1);
    check("R7 reads", nrd, 1);
    check("R7 no write", nwr, 0);
    check("R7 no further slot", xr, 0);
    check("R10 err held", err_o, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule